// File: doc/BRIEF.md
# Shared-Memory Coherence Directory Controller

This block sits in front of the main memory that several private caches share. Next to the word-per-block data store it keeps a small flag table. For every block the table holds one presence bit per cache and one dirty bit. The dirty bit means that some cache holds a newer copy than memory. Processors never see this table.

Caches send commands over per-cache request lanes. The commands are: a fetch for reading, a fetch for ownership, an ownership upgrade, a write-back, a drop notice, and a combined write-back-and-drop. When a fetch or upgrade needs the other copies recalled or invalidated, the controller sends an invalidate or a recall. It sends them one at a time, and only to caches whose presence bit is set. It waits for each target to signal completion. While it waits, it accepts that target's write-back or drop as a nested request, so that no cache ever waits on a controller that is waiting on it.

New requests are arbitrated round-robin. One top-level transaction is in progress at a time.

Top module: `dirmem_ctrl`

## Requirements
- R1: After reset every presence bit and every dirty bit is clear, and no ack or snoop is asserted. A fetch of any block that follows reset causes no snoop.
- R2: For a read fetch (op 0), a recall (snp_purge=0) goes to each other cache whose presence bit is set, but only when the block's dirty bit is set. When the dirty bit is clear, no snoop is sent.
- R3: For an ownership fetch (op 1), an invalidate (snp_purge=1) goes to every other present cache. The requester is never snooped.
- R4: A fetch completes with rsp_data holding the memory word of the block, including any data written back during the fetch. Completion sets the requester's presence bit and sets the dirty bit to 1 for op 1 and to 0 for op 0.
- R5: An ownership upgrade (op 2) invalidates every other present cache and then sets the dirty bit.
- R6: A write-back (op 3) stores req_data into the block's memory word.
- R7: A drop notice (op 4) clears the sender's presence bit for the block. Later fetches no longer snoop that cache.
- R8: A write-back-and-drop (op 5) stores the data, clears the sender's presence bit and clears the dirty bit.
- R9: At most one snoop is outstanding. Each snoop is a one-cycle pulse to exactly one cache. The controller waits for that cache's one-cycle snp_done before the next snoop or before completing. During the wait it serves an op 3, 4 or 5 for the same block from the snooped cache.
- R10: Pending new requests are granted round-robin, starting after the last cache granted. After reset the first candidate is cache 0.
- R11: Handshake: a cache holds req_valid, op, block and data until req_ack is high. req_ack is a one-cycle pulse, and the cache must drop or change its request before the following clock edge. rsp_data is valid in the ack cycle of a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_CACHE | Request present, one bit per cache |
| req_op | input | 3*N_CACHE | Command code per cache (see R2-R8) |
| req_blk | input | BW*N_CACHE | Block number per cache |
| req_data | input | DATA_W*N_CACHE | Write data per cache |
| req_ack | output | N_CACHE | One-cycle completion pulse per cache |
| rsp_data | output | DATA_W | Fetched block word |
| snp_valid | output | N_CACHE | One-cycle snoop pulse to one cache |
| snp_purge | output | 1 | 1 = invalidate, 0 = recall |
| snp_blk | output | BW | Block number of the snoop |
| snp_done | input | N_CACHE | Snoop completion pulse per cache |

## Verification
The bench builds the default configuration of four caches and sixteen one-word blocks. With four caches, a single block can be held by up to three non-requesting caches at once, so fan-out of invalidates and the filtering of recalls by presence and dirty state can both be observed. Four lanes also make the rotating grant order observable. Cache models in the bench answer snoops with nothing, a drop, a write-back, or a write-back-and-drop. This exercises the nested path and shows recalled data arriving in the fetch response.

// File: rtl/dirmem_pkg.sv
package dirmem_pkg;
  typedef enum logic [2:0] {
    OP_FETCH  = 3'd0,
    OP_OWN    = 3'd1,
    OP_UPG    = 3'd2,
    OP_WB     = 3'd3,
    OP_DROP   = 3'd4,
    OP_WBDROP = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_SNOOP, ST_WAIT, ST_FINISH
  } st_e;

  function automatic logic is_retire(logic [2:0] op);
    return (op == OP_WB) || (op == OP_DROP) || (op == OP_WBDROP);
  endfunction
endpackage

// File: rtl/dir_ram.sv
module dir_ram #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dir_flags.sv
module dir_flags #(
  parameter int N_CACHE = 4,
  parameter int N_BLK   = 16,
  localparam int IW = (N_CACHE > 1) ? $clog2(N_CACHE) : 1,
  localparam int BW = (N_BLK > 1) ? $clog2(N_BLK) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BW-1:0]      idx,
  input  logic [IW-1:0]      who,
  input  logic               set_en,
  input  logic               clr_en,
  input  logic               mod_we,
  input  logic               mod_d,
  output logic [N_CACHE-1:0] pres_o,
  output logic               mod_o
);
  logic [N_CACHE-1:0] pres [N_BLK];
  logic [N_BLK-1:0]   dirty;

  assign pres_o = pres[idx];
  assign mod_o  = dirty[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < N_BLK; b++) pres[b] <= '0;
      dirty <= '0;
    end else begin
      if (set_en) pres[idx][who] <= 1'b1;
      if (clr_en) pres[idx][who] <= 1'b0;
      if (mod_we) dirty[idx] <= mod_d;
    end
  end

  // checker state: remember a clear to see that it took effect
  logic          chk_clr;
  logic [BW-1:0] chk_idx;
  logic [IW-1:0] chk_who;
  always_ff @(posedge clk) begin
    if (rst) chk_clr <= 1'b0;
    else     chk_clr <= clr_en && !set_en;
    chk_idx <= idx;
    chk_who <= who;
  end

  a_r7_drop_clears: assert property (@(posedge clk) disable iff (rst)
    chk_clr |-> !pres[chk_idx][chk_who]);
  a_r1_no_set_clr_clash: assert property (@(posedge clk) disable iff (rst)
    !(set_en && clr_en));
endmodule

// File: rtl/dir_rr_arb.sv
module dir_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [IW-1:0] gnt_id,
  output logic          gnt_any
);
  logic [IW-1:0] last;

  always_comb begin
    gnt_id  = '0;
    gnt_any = 1'b0;
    for (int k = N; k >= 1; k--) begin
      int c;
      c = int'(last) + k;
      if (c >= N) c = c - N;
      if (req[c]) begin
        gnt_id  = IW'(c);
        gnt_any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       last <= IW'(N - 1);
    else if (take) last <= gnt_id;
  end

  a_r10_grant_is_request: assert property (@(posedge clk) disable iff (rst)
    gnt_any |-> req[gnt_id]);
endmodule

// File: rtl/dirmem_ctrl.sv
module dirmem_ctrl
  import dirmem_pkg::*;
#(
  parameter int N_CACHE = 4,
  parameter int N_BLK   = 16,
  parameter int DATA_W  = 32,
  localparam int IW = (N_CACHE > 1) ? $clog2(N_CACHE) : 1,
  localparam int BW = (N_BLK > 1) ? $clog2(N_BLK) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_CACHE-1:0]        req_valid,
  input  logic [3*N_CACHE-1:0]      req_op,
  input  logic [BW*N_CACHE-1:0]     req_blk,
  input  logic [DATA_W*N_CACHE-1:0] req_data,
  output logic [N_CACHE-1:0]        req_ack,
  output logic [DATA_W-1:0]         rsp_data,
  output logic [N_CACHE-1:0]        snp_valid,
  output logic                      snp_purge,
  output logic [BW-1:0]             snp_blk,
  input  logic [N_CACHE-1:0]        snp_done
);
  logic [2:0]        r_op   [N_CACHE];
  logic [BW-1:0]     r_blk  [N_CACHE];
  logic [DATA_W-1:0] r_data [N_CACHE];

  for (genvar i = 0; i < N_CACHE; i++) begin : g_lane
    assign r_op[i]   = req_op[3*i +: 3];
    assign r_blk[i]  = req_blk[BW*i +: BW];
    assign r_data[i] = req_data[DATA_W*i +: DATA_W];
  end

  st_e                state;
  logic [IW-1:0]      cur_id, tgt;
  logic [2:0]         cur_op;
  logic [BW-1:0]      cur_blk;
  logic [N_CACHE-1:0] pend;

  logic [IW-1:0]      gnt_id;
  logic               gnt_any;
  logic [N_CACHE-1:0] dir_pres;
  logic               dir_mod;
  logic [BW-1:0]      dir_idx;
  logic [IW-1:0]      dir_who;
  logic               dir_set, dir_clr, mod_we, mod_d;
  logic               ram_we;
  logic [BW-1:0]      ram_wa;
  logic [DATA_W-1:0]  ram_wd;
  logic [N_CACHE-1:0] new_mask;
  logic [IW-1:0]      nxt_tgt;
  logic               nest_ok;
  logic [2:0]         act_op;

  dir_rr_arb #(.N(N_CACHE)) arb_i (
    .clk(clk), .rst(rst),
    .req((state == ST_IDLE) ? req_valid : '0),
    .take((state == ST_IDLE) && gnt_any),
    .gnt_id(gnt_id), .gnt_any(gnt_any)
  );

  dir_flags #(.N_CACHE(N_CACHE), .N_BLK(N_BLK)) flags_i (
    .clk(clk), .rst(rst), .idx(dir_idx), .who(dir_who),
    .set_en(dir_set), .clr_en(dir_clr), .mod_we(mod_we), .mod_d(mod_d),
    .pres_o(dir_pres), .mod_o(dir_mod)
  );

  dir_ram #(.DEPTH(N_BLK), .DATA_W(DATA_W)) ram_i (
    .clk(clk), .we(ram_we), .waddr(ram_wa), .wdata(ram_wd),
    .raddr(cur_blk), .rdata(rsp_data)
  );

  assign nest_ok = (state == ST_WAIT) && req_valid[tgt] &&
                   (r_blk[tgt] == cur_blk) && is_retire(r_op[tgt]);

  // snoop set for a newly granted fetch or upgrade
  always_comb begin
    logic [N_CACHE-1:0] others;
    others = dir_pres & ~(N_CACHE'(1) << gnt_id);
    if (r_op[gnt_id] == OP_FETCH) new_mask = dir_mod ? others : '0;
    else                          new_mask = others;
  end

  // lowest pending target first
  always_comb begin
    nxt_tgt = '0;
    for (int k = N_CACHE - 1; k >= 0; k--)
      if (pend[k]) nxt_tgt = IW'(k);
  end

  // directory and memory write controls
  always_comb begin
    dir_idx = cur_blk;
    dir_who = cur_id;
    dir_set = 1'b0;
    dir_clr = 1'b0;
    mod_we  = 1'b0;
    mod_d   = 1'b0;
    ram_we  = 1'b0;
    ram_wa  = cur_blk;
    ram_wd  = '0;
    act_op  = OP_FETCH;
    if (state == ST_IDLE && gnt_any) begin
      dir_idx = r_blk[gnt_id];
      dir_who = gnt_id;
      ram_wa  = r_blk[gnt_id];
      ram_wd  = r_data[gnt_id];
      act_op  = r_op[gnt_id];
    end else if (nest_ok) begin
      dir_who = tgt;
      ram_wd  = r_data[tgt];
      act_op  = r_op[tgt];
    end
    if ((state == ST_IDLE && gnt_any) || nest_ok) begin
      ram_we  = (act_op == OP_WB) || (act_op == OP_WBDROP);
      dir_clr = (act_op == OP_DROP) || (act_op == OP_WBDROP);
      if (act_op == OP_WBDROP) mod_we = 1'b1;
    end
    if (state == ST_FINISH) begin
      mod_we  = 1'b1;
      mod_d   = (cur_op != OP_FETCH);
      dir_set = (cur_op != OP_UPG);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_ack   <= '0;
      snp_valid <= '0;
      snp_purge <= 1'b0;
      snp_blk   <= '0;
      pend      <= '0;
      cur_id    <= '0;
      cur_op    <= '0;
      cur_blk   <= '0;
      tgt       <= '0;
    end else begin
      req_ack   <= '0;
      snp_valid <= '0;
      unique case (state)
        ST_IDLE: if (gnt_any) begin
          cur_id  <= gnt_id;
          cur_op  <= r_op[gnt_id];
          cur_blk <= r_blk[gnt_id];
          if (is_retire(r_op[gnt_id])) begin
            req_ack[gnt_id] <= 1'b1;
          end else begin
            pend  <= new_mask;
            state <= (new_mask != '0) ? ST_SNOOP : ST_FINISH;
          end
        end
        ST_SNOOP: begin
          tgt                <= nxt_tgt;
          snp_valid[nxt_tgt] <= 1'b1;
          snp_purge          <= (cur_op != OP_FETCH);
          snp_blk            <= cur_blk;
          state              <= ST_WAIT;
        end
        ST_WAIT: begin
          if (nest_ok) req_ack[tgt] <= 1'b1;
          if (snp_done[tgt]) begin
            pend[tgt] <= 1'b0;
            state <= ((pend & ~(N_CACHE'(1) << tgt)) != '0) ? ST_SNOOP : ST_FINISH;
          end
        end
        ST_FINISH: begin
          req_ack[cur_id] <= 1'b1;
          state           <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r9_one_snoop: assert property (@(posedge clk) disable iff (rst)
    $onehot0(snp_valid));
  a_r9_snoop_while_waiting: assert property (@(posedge clk) disable iff (rst)
    (snp_valid != '0) |-> (state == ST_WAIT));
  a_r3_requester_never_snooped: assert property (@(posedge clk) disable iff (rst)
    (snp_valid != '0) |-> !snp_valid[cur_id]);
  a_r2_snoop_only_present: assert property (@(posedge clk) disable iff (rst)
    ((snp_valid & ~dir_pres) == '0));
  a_r11_single_ack: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_ack));
  a_r11_ack_is_pulse: assert property (@(posedge clk) disable iff (rst)
    (req_ack != '0) |=> ((req_ack & $past(req_ack)) == '0));
endmodule

// File: tb/dirmem_ctrl_tb_top.sv
`timescale 1ns/1ps
module dirmem_ctrl_tb_top;
  localparam int NC = 4;
  localparam int NB = 16;
  localparam int DW = 32;
  localparam int BW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [NC-1:0]    req_valid, req_ack, snp_valid, snp_done;
  logic [3*NC-1:0]  req_op;
  logic [BW*NC-1:0] req_blk;
  logic [DW*NC-1:0] req_data;
  logic [DW-1:0]    rsp_data;
  logic             snp_purge;
  logic [BW-1:0]    snp_blk;

  // task side and snoop responder side of each cache lane
  logic          t_valid [NC];
  logic [2:0]    t_op    [NC];
  logic [BW-1:0] t_blk   [NC];
  logic [DW-1:0] t_data  [NC];
  logic          r_valid [NC];
  logic [2:0]    r_op    [NC];
  logic [DW-1:0] r_data  [NC];
  logic          r_done  [NC];
  int            wb_mode [NC];
  logic [DW-1:0] wb_data [NC];
  int            upd_cnt [NC];
  int            pur_cnt [NC];

  int n_tests = 0;
  int n_fail  = 0;
  int seq     = 0;

  for (genvar i = 0; i < NC; i++) begin : g_cache
    assign req_valid[i]            = r_valid[i] | t_valid[i];
    assign req_op[3*i +: 3]        = r_valid[i] ? r_op[i] : t_op[i];
    assign req_blk[BW*i +: BW]     = r_valid[i] ? snp_blk : t_blk[i];
    assign req_data[DW*i +: DW]    = r_valid[i] ? r_data[i] : t_data[i];
    assign snp_done[i]             = r_done[i];

    int st;
    initial begin
      st = 0; r_valid[i] = 0; r_op[i] = 0; r_data[i] = 0; r_done[i] = 0;
      upd_cnt[i] = 0; pur_cnt[i] = 0;
    end
    always @(negedge clk) begin
      case (st)
        0: if (snp_valid[i]) begin
          if (snp_purge) pur_cnt[i] = pur_cnt[i] + 1;
          else           upd_cnt[i] = upd_cnt[i] + 1;
          if (wb_mode[i] == 1) begin
            r_valid[i] = 1; r_data[i] = wb_data[i];
            r_op[i] = snp_purge ? 3'd5 : 3'd3;
            st = 1;
          end else if (wb_mode[i] == 2 && snp_purge) begin
            r_valid[i] = 1; r_op[i] = 3'd4; st = 1;
          end else begin
            r_done[i] = 1; st = 2;
          end
        end
        1: if (req_ack[i]) begin
          r_valid[i] = 0; r_done[i] = 1; st = 2;
        end
        default: begin
          r_done[i] = 0; st = 0;
        end
      endcase
    end
  end

  dirmem_ctrl #(.N_CACHE(NC), .N_BLK(NB), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_blk(req_blk), .req_data(req_data), .req_ack(req_ack),
    .rsp_data(rsp_data), .snp_valid(snp_valid), .snp_purge(snp_purge),
    .snp_blk(snp_blk), .snp_done(snp_done)
  );

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(int c, logic [2:0] op, int blk, logic [DW-1:0] d,
                       output logic [DW-1:0] q, output int stamp);
    int guard;
    @(negedge clk);
    t_valid[c] = 1; t_op[c] = op; t_blk[c] = BW'(blk); t_data[c] = d;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!req_ack[c] && guard < 200);
    if (!req_ack[c]) check("R11 ack timeout", 0, 1);
    q = rsp_data;
    seq++;
    stamp = seq;
    t_valid[c] = 0;
  endtask

  task automatic snap(output int u [NC], output int p [NC]);
    for (int i = 0; i < NC; i++) begin u[i] = upd_cnt[i]; p[i] = pur_cnt[i]; end
  endtask

  task automatic t_reset;
    logic [DW-1:0] q; int s; int u0 [NC]; int p0 [NC];
    check("R1 ack after reset", 32'(req_ack), 0);
    check("R1 snoop after reset", 32'(snp_valid), 0);
    snap(u0, p0);
    issue(0, 3'd1, 3, 0, q, s);
    check("R1 no snoop after reset", upd_cnt[1] + pur_cnt[1] + pur_cnt[2] + pur_cnt[3],
          u0[1] + p0[1] + p0[2] + p0[3]);
  endtask

  task automatic t_write_read;
    logic [DW-1:0] q; int s; int u0 [NC]; int p0 [NC];
    issue(1, 3'd3, 5, 32'hA5A5_0005, q, s);
    snap(u0, p0);
    issue(0, 3'd0, 5, 0, q, s);
    check("R6 written word fetched", q, 32'hA5A5_0005);
    issue(2, 3'd0, 5, 0, q, s);
    check("R2 clean block no recall", upd_cnt[0] + pur_cnt[0], u0[0] + p0[0]);
    check("R4 fetch data", q, 32'hA5A5_0005);
  endtask

  task automatic t_own;
    logic [DW-1:0] q; int s; int u0 [NC]; int p0 [NC];
    wb_mode[0] = 2; wb_mode[2] = 2;
    snap(u0, p0);
    issue(1, 3'd1, 5, 0, q, s);
    check("R3 invalidate cache0", pur_cnt[0], p0[0] + 1);
    check("R3 invalidate cache2", pur_cnt[2], p0[2] + 1);
    check("R3 requester not snooped", pur_cnt[1] + upd_cnt[1], p0[1] + u0[1]);
    check("R3 absent cache not snooped", pur_cnt[3], p0[3]);
    check("R4 own fetch data", q, 32'hA5A5_0005);
  endtask

  task automatic t_recall;
    logic [DW-1:0] q; int s; int u0 [NC]; int p0 [NC];
    wb_mode[1] = 1; wb_data[1] = 32'h1111_0001;
    snap(u0, p0);
    issue(3, 3'd0, 5, 0, q, s);
    check("R2 recall to dirty owner", upd_cnt[1], u0[1] + 1);
    check("R7 dropped caches not snooped", pur_cnt[0] + upd_cnt[0] + pur_cnt[2] + upd_cnt[2],
          p0[0] + u0[0] + p0[2] + u0[2]);
    check("R9 nested write-back reaches fetch", q, 32'h1111_0001);
  endtask

  task automatic t_upgrade;
    logic [DW-1:0] q; int s; int u0 [NC]; int p0 [NC];
    wb_mode[1] = 2;
    snap(u0, p0);
    issue(3, 3'd2, 5, 0, q, s);
    check("R5 upgrade invalidates cache1", pur_cnt[1], p0[1] + 1);
    check("R5 upgrade no recall", upd_cnt[0] + upd_cnt[1] + upd_cnt[2], u0[0] + u0[1] + u0[2]);
    wb_mode[3] = 1; wb_data[3] = 32'h2222_0002;
    snap(u0, p0);
    issue(0, 3'd1, 5, 0, q, s);
    check("R8 write-back-and-drop data", q, 32'h2222_0002);
    check("R5 dirty after upgrade gives invalidate", pur_cnt[3], p0[3] + 1);
    wb_mode[0] = 0;
    snap(u0, p0);
    issue(2, 3'd0, 5, 0, q, s);
    check("R4 own fetch leaves dirty: recall", upd_cnt[0], u0[0] + 1);
    check("R8 dropped sender not snooped", upd_cnt[3] + pur_cnt[3], u0[3] + p0[3]);
    snap(u0, p0);
    issue(1, 3'd0, 5, 0, q, s);
    check("R4 read fetch clears dirty", upd_cnt[0] + upd_cnt[2], u0[0] + u0[2]);
  endtask

  task automatic t_drop;
    logic [DW-1:0] q; int s; int u0 [NC]; int p0 [NC];
    issue(0, 3'd4, 5, 0, q, s);
    wb_mode[1] = 0; wb_mode[2] = 0;
    snap(u0, p0);
    issue(3, 3'd1, 5, 0, q, s);
    check("R7 drop stops invalidate", pur_cnt[0], p0[0]);
    check("R3 present caches invalidated", pur_cnt[1] + pur_cnt[2], p0[1] + p0[2] + 2);
  endtask

  task automatic t_rr;
    logic [DW-1:0] q1, q3, q; int s1, s3, s;
    issue(2, 3'd3, 7, 32'h7777_0007, q, s);
    fork
      issue(1, 3'd3, 8, 32'h8888_0008, q1, s1);
      issue(3, 3'd3, 9, 32'h9999_0009, q3, s3);
    join
    check("R10 cache3 before cache1 after cache2", 32'(s3 < s1), 1);
    issue(0, 3'd0, 9, 0, q, s);
    check("R6 block9 stored", q, 32'h9999_0009);
    issue(0, 3'd0, 8, 0, q, s);
    check("R6 block8 stored", q, 32'h8888_0008);
  endtask

  initial begin
    for (int i = 0; i < NC; i++) begin
      t_valid[i] = 0; t_op[i] = 0; t_blk[i] = 0; t_data[i] = 0;
      wb_mode[i] = 0; wb_data[i] = 0;
    end
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_own();
    t_recall();
    t_upgrade();
    t_drop();
    t_rr();
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule